// File: doc/BRIEF.md
# VBI Dual Slice-Line Selector

This block decides which horizontal line of the vertical blanking interval is passed to a downstream data slicer. It serves two independent targets, a main one and a sub one. The vertical and horizontal sync separator pulses come from the video front end. Both are brought into the system clock domain and edge-detected. A single shared line counter is cleared when vertical sync ends and advances on each horizontal sync pulse. Each target compares that count with its own programmed 5-bit line number. When the two are equal and the current field is allowed, the target raises its slice enable for that one line.

The block also reports which field is in progress. At the end of vertical sync it looks at how far the current line has run since the last horizontal sync edge and compares that with the measured line length. A vertical sync that ends early in a line marks the first field. One that ends late in a line marks the second field. The field-selection code of each target can limit its enable to one field or allow it in both.

Top module: `vbi_slice_line_sel`

## Requirements
- R1: The falling edge of the synchronized vertical sync clears the line count to 0. The line in which that edge occurs is line 0.
- R2: Every rising edge of the synchronized horizontal sync after that clear advances the line count by one.
- R3: The line count stops at 31 and does not wrap. Once a 32nd pulse has arrived, neither enable can assert again until the next clear.
- R4: `main_slice_o` is high during the line whose count equals `main_line_i`, provided the current field is allowed by `main_fsel_i`. It is low in every other line.
- R5: `sub_slice_o` follows the same rule using `sub_line_i` and `sub_fsel_i`. It is independent of the main target.
- R6: The field-selection code works as follows. Bit 1 = 1 allows both fields. Code 00 allows only field 0. Code 01 allows only field 1. The enable is suppressed in any field that is not allowed.
- R7: At each vertical sync falling edge, `field_o` is set to 0 when fewer than half a measured line period (the spacing between the last two horizontal edges) have elapsed since the last horizontal edge. Otherwise it is set to 1. It holds that value until the next vertical sync falling edge.
- R8: After reset, neither enable asserts until the first vertical sync falling edge has occurred, whatever the line count.
- R9: During reset both enables and `field_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vsep_i | input | 1 | Vertical sync separator pulse, asynchronous |
| hsep_i | input | 1 | Horizontal sync separator pulse, asynchronous |
| main_line_i | input | 5 | Line number for the main target |
| main_fsel_i | input | 2 | Field-selection code for the main target |
| sub_line_i | input | 5 | Line number for the sub target |
| sub_fsel_i | input | 2 | Field-selection code for the sub target |
| main_slice_o | output | 1 | Slice enable for the main target |
| sub_slice_o | output | 1 | Slice enable for the sub target |
| field_o | output | 1 | Current field identity |

## Verification
The hardest state to reach from the ports is a field decision that depends on where the vertical sync edge falls relative to the horizontal timing. That decision needs a measured line period, so the stimulus first runs several plain lines to train the period. It then ends vertical sync either three cycles or twenty-eight cycles into a forty-cycle line, which gives both field outcomes. A sweep covers every main line number, every field-selection code and both fields. Each field runs 34 lines, which drives the counter into saturation so that the match at line 31 and the suppression beyond it are both checked.

// File: rtl/vbi_sel_pkg.sv
package vbi_sel_pkg;

    localparam int LINE_W  = 5;
    localparam int NUM_TGT = 2;
    localparam int TGT_MAIN = 0;
    localparam int TGT_SUB  = 1;

    typedef logic [LINE_W-1:0] line_t;
    localparam line_t LINE_LAST = '1;

    typedef enum logic [1:0] {
        FSEL_FIELD0 = 2'b00,
        FSEL_FIELD1 = 2'b01,
        FSEL_BOTH_A = 2'b10,
        FSEL_BOTH_B = 2'b11
    } fsel_e;

    typedef struct packed {
        logic  valid;   // a vertical sync end has been seen since reset
        logic  ovf;     // more pulses than the count can hold
        line_t cnt;
    } lcnt_t;

    function automatic logic field_allowed(input logic [1:0] sel, input logic fld);
        return sel[1] | (sel[0] == fld);
    endfunction

endpackage

// File: rtl/vbi_sync_edge.sv
module vbi_sync_edge #(
    parameter int N         = 2,
    parameter int STAGES    = 2,
    parameter logic [N-1:0] FALL_MASK = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] edge_o
);

    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        logic [STAGES-1:0] shreg;
        logic              prev;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                shreg <= '0;
                prev  <= 1'b0;
            end else begin
                shreg <= {shreg[STAGES-2:0], async_i[gi]};
                prev  <= shreg[STAGES-1];
            end
        end

        if (FALL_MASK[gi]) begin : g_fall
            assign edge_o[gi] = prev & ~shreg[STAGES-1];
        end else begin : g_rise
            assign edge_o[gi] = ~prev & shreg[STAGES-1];
        end
    end

endmodule

// File: rtl/vbi_line_counter.sv
module vbi_line_counter
    import vbi_sel_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  vs_fall_i,
    input  logic  hs_rise_i,
    output lcnt_t st_o
);

    lcnt_t st;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st <= '{valid: 1'b0, ovf: 1'b0, cnt: '0};
        end else if (vs_fall_i) begin
            st <= '{valid: 1'b1, ovf: 1'b0, cnt: '0};
        end else if (hs_rise_i) begin
            if (st.cnt == LINE_LAST) st.ovf <= 1'b1;
            else                     st.cnt <= st.cnt + 1'b1;
        end
    end

    assign st_o = st;

    // R1: the end of vertical sync restarts the count
    a_r1_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        vs_fall_i |=> (st.cnt == '0 && !st.ovf && st.valid));

    // R3: overflow sticks until the next clear
    a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (st.ovf && !vs_fall_i) |=> st.ovf);

    // R2: the count never moves without a horizontal edge
    a_r2_quiet_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!vs_fall_i && !hs_rise_i) |=> $stable(st.cnt));

endmodule

// File: rtl/vbi_field_detect.sv
module vbi_field_detect #(
    parameter int TIMER_W = 12
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic vs_fall_i,
    input  logic hs_rise_i,
    output logic field_o
);

    localparam logic [TIMER_W-1:0] T_MAX = '1;

    logic [TIMER_W-1:0] elapsed;
    logic [TIMER_W-1:0] period;
    logic               field_q;
    logic [TIMER_W:0]   twice_el;

    assign twice_el = {elapsed, 1'b0};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            elapsed <= '0;
            period  <= '0;
        end else if (hs_rise_i) begin
            period  <= (elapsed == T_MAX) ? T_MAX : elapsed + 1'b1;
            elapsed <= '0;
        end else if (elapsed != T_MAX) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)          field_q <= 1'b0;
        else if (vs_fall_i) field_q <= (twice_el >= {1'b0, period});
    end

    assign field_o = field_q;

    // R7: the field identity changes only at the end of vertical sync
    a_r7_field_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !vs_fall_i |=> $stable(field_q));

endmodule

// File: rtl/vbi_line_match.sv
module vbi_line_match
    import vbi_sel_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  lcnt_t      st_i,
    input  line_t      line_i,
    input  logic [1:0] fsel_i,
    input  logic       field_i,
    output logic       slice_o
);

    logic hit;

    assign hit     = st_i.valid && !st_i.ovf && (st_i.cnt == line_i);
    assign slice_o = hit && field_allowed(fsel_i, field_i);

    // R3: no enable once the count has run past its end
    a_r3_no_slice_past_end: assert property (@(posedge clk_i) disable iff (rst_i)
        st_i.ovf |-> !slice_o);

    // R6: a single-field code blocks the other field
    a_r6_field_gate: assert property (@(posedge clk_i) disable iff (rst_i)
        (slice_o && !fsel_i[1]) |-> (field_i == fsel_i[0]));

    // R8: nothing before the first vertical sync end
    a_r8_wait_first_vsync: assert property (@(posedge clk_i) disable iff (rst_i)
        !st_i.valid |-> !slice_o);

endmodule

// File: rtl/vbi_slice_line_sel.sv
module vbi_slice_line_sel
    import vbi_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TIMER_W     = 12
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       vsep_i,
    input  logic       hsep_i,
    input  logic [4:0] main_line_i,
    input  logic [1:0] main_fsel_i,
    input  logic [4:0] sub_line_i,
    input  logic [1:0] sub_fsel_i,
    output logic       main_slice_o,
    output logic       sub_slice_o,
    output logic       field_o
);

    localparam int EV_HS = 0;
    localparam int EV_VS = 1;

    logic [1:0] ev;
    lcnt_t      st;
    logic       field;

    line_t              tgt_line [NUM_TGT];
    logic [1:0]         tgt_fsel [NUM_TGT];
    logic [NUM_TGT-1:0] tgt_slice;

    vbi_sync_edge #(
        .N         (2),
        .STAGES    (SYNC_STAGES),
        .FALL_MASK (2'b10)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i ({vsep_i, hsep_i}),
        .edge_o  (ev)
    );

    vbi_line_counter cnt_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .vs_fall_i (ev[EV_VS]),
        .hs_rise_i (ev[EV_HS]),
        .st_o      (st)
    );

    vbi_field_detect #(
        .TIMER_W (TIMER_W)
    ) fld_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .vs_fall_i (ev[EV_VS]),
        .hs_rise_i (ev[EV_HS]),
        .field_o   (field)
    );

    assign tgt_line[TGT_MAIN] = main_line_i;
    assign tgt_fsel[TGT_MAIN] = main_fsel_i;
    assign tgt_line[TGT_SUB]  = sub_line_i;
    assign tgt_fsel[TGT_SUB]  = sub_fsel_i;

    for (genvar gt = 0; gt < NUM_TGT; gt++) begin : g_tgt
        vbi_line_match match_i (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .st_i    (st),
            .line_i  (tgt_line[gt]),
            .fsel_i  (tgt_fsel[gt]),
            .field_i (field),
            .slice_o (tgt_slice[gt])
        );
    end

    assign main_slice_o = tgt_slice[TGT_MAIN];
    assign sub_slice_o  = tgt_slice[TGT_SUB];
    assign field_o      = field;

    // R4: the main enable only in its programmed line
    a_r4_main_on_line: assert property (@(posedge clk_i) disable iff (rst_i)
        main_slice_o |-> (st.cnt == main_line_i));

    // R5: the sub enable only in its programmed line
    a_r5_sub_on_line: assert property (@(posedge clk_i) disable iff (rst_i)
        sub_slice_o |-> (st.cnt == sub_line_i));

    // R9: outputs quiet in the cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk_i)
        rst_i |=> (!main_slice_o && !sub_slice_o && !field_o));

endmodule

// File: tb/vbi_slice_line_sel_tb.sv
module vbi_slice_line_sel_tb_top;

    localparam int P      = 40;   // clocks per video line
    localparam int HS_LEN = 4;
    localparam int D_EARLY = 3;
    localparam int D_LATE  = 28;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vsep = 1'b0;
    logic       hsep = 1'b0;
    logic [4:0] main_line = '0;
    logic [1:0] main_fsel = '0;
    logic [4:0] sub_line = '0;
    logic [1:0] sub_fsel = '0;
    logic       main_slice, sub_slice, field;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    vbi_slice_line_sel dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .vsep_i       (vsep),
        .hsep_i       (hsep),
        .main_line_i  (main_line),
        .main_fsel_i  (main_fsel),
        .sub_line_i   (sub_line),
        .sub_fsel_i   (sub_fsel),
        .main_slice_o (main_slice),
        .sub_slice_o  (sub_slice),
        .field_o      (field)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic allow(input int sel, input int fld);
        if (sel >= 2) return 1'b1;
        return (sel == fld) ? 1'b1 : 1'b0;
    endfunction

    // One video line. vfall < 0: no vertical sync in this line.
    task automatic run_line(input int vfall, input logic exp_m, input logic exp_s,
                            input logic exp_f, input string tag_m, input string tag_s);
        for (int c = 0; c < P; c++) begin
            @(negedge clk);
            hsep = (c < HS_LEN);
            if (vfall >= 0 && c == 0) vsep = 1'b1;
            if (c == vfall) vsep = 1'b0;
            if (c == P - 3) begin
                check(tag_m, main_slice, exp_m);
                check(tag_s, sub_slice, exp_s);
                check("R7 field flag", field, exp_f);
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R9 main reset", main_slice, 1'b0);
        check("R9 sub reset", sub_slice, 1'b0);
        check("R9 field reset", field, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R8: count runs through line 2 without a vertical sync end
        main_line = 5'd2; main_fsel = 2'd2;
        sub_line  = 5'd1; sub_fsel  = 2'd3;
        for (int w = 0; w < 4; w++)
            run_line(-1, 1'b0, 1'b0, 1'b0, "R8 main pre-vsync", "R8 sub pre-vsync");

        for (int i = 0; i < 64; i++) begin
            int fld = i % 2;
            int ml  = i / 2;
            int mf  = (i / 2) % 4;
            int sl  = 31 - ml;
            int sf  = (i / 2 + 1) % 4;
            main_line = 5'(ml); main_fsel = 2'(mf);
            sub_line  = 5'(sl); sub_fsel  = 2'(sf);
            for (int j = 0; j < 34; j++) begin
                logic em, es;
                string tm, ts;
                em = (j <= 31) && (j == ml) && allow(mf, fld);
                es = (j <= 31) && (j == sl) && allow(sf, fld);
                if (j > 31)                          tm = "R3 main past end";
                else if (j == ml && !allow(mf, fld)) tm = "R6 main field gate";
                else if (j == 0)                     tm = "R1 main line0";
                else                                 tm = "R2,R4 main match";
                if (j > 31)                          ts = "R3 sub past end";
                else if (j == sl && !allow(sf, fld)) ts = "R6 sub field gate";
                else                                 ts = "R5 sub match";
                run_line((j == 0) ? ((fld != 0) ? D_LATE : D_EARLY) : -1,
                         em, es, fld[0], tm, ts);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule